// File: doc/BRIEF.md
# MDIO Management Read Master with Continuous Scan

This block is a management-interface master that issues clause-22 MDIO read frames to an external PHY. Software sets up a target in an address register and then starts a transfer through a command register. A single read starts on a rising edge of a level-style command bit. A scan bit makes the block poll the same PHY register back to back with no further software action, which suits link-state monitoring. Each 16-bit result lands in a status register, and a busy indicator reports when a transfer is in flight.

MDC is made from the system clock by a parameterised even divider. MDIO leaves the block as separate data and output-enable signals, so the pad tri-state sits outside. A flat register port with one shared select serves both writes and reads. Each frame has 64 MDC periods: 32 preamble ones, start `01`, read opcode `10`, the PHY address and the register address (each 5 bits, MSB first), two turnaround periods with MDIO released, and 16 data bits, MSB first.

Top module: `mdio_scan_master`

## Requirements
- R1: After reset, the address fields, both command bits, busy and the status word all read 0, and `mdio_oe` is 0.
- R2: MDC has a period of `CLK_DIV` system clocks and is high for half of them. `mdio_o` and `mdio_oe` change only on MDC falling edges, and input data is captured on MDC rising edges.
- R3: A frame drives exactly 32 ones, then `0,1`, then opcode `1,0`, then the PHY address and register address MSB first. After that it releases MDIO (`mdio_oe`=0) for the two turnaround bits and the 16 data bits.
- R4: Select 0 is the address register, with the PHY address in bits 9:5 and the register address in bits 4:0. A frame carries the values these fields hold when the frame starts.
- R5: Select 1 is the command register, with the single-read bit at bit 0 and the scan bit at bit 1. Only a 0-to-1 change of bit 0 starts a read. Hardware never clears the bit, and while it stays at 1 no further frame starts.
- R6: Select 2 bit 0 is busy. It reads 1 within three system clocks of an accepted read edge. It returns to 0 once the frame's last data bit has been captured.
- R7: Select 3 holds the 16 bits sampled in the data phase, first-sampled bit as MSB. It changes only when a frame completes.
- R8: While the scan bit is 1, frames run back to back and busy stays 1. The status word updates after every frame.
- R9: Clearing the scan bit lets the frame in progress finish. No further frame starts, and busy then falls.
- R10: A 0-to-1 change of the read bit while busy is 1 is ignored and does not start an extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_sel | input | 2 | Register select: 0 address, 1 command, 2 indicator, 3 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = block drives the line) |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The hardest situations to reach from the ports are the ones that depend on where a frame stands when software acts. Examples are a second read edge that lands mid-frame, or a scan bit that is cleared just after a new scan frame has begun. The bench includes a PHY model that decodes each frame from `mdc`, `mdio_o` and `mdio_oe`, and that model counts finished frames. Stimulus waits on that count and then acts a fixed number of clocks later, which places the command write inside a known frame. Frame counts checked afterwards show whether an extra frame was started or a frame was cut short.

// File: rtl/mdio_pkg.sv
// Package: shared constants and types for the MDIO read master.
// Assumes clause-22 read frames of fixed 64-bit length.
package mdio_pkg;
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 14;   // start(2) + opcode(2) + phy(5) + reg(5)
    localparam int TA_BITS    = 2;
    localparam int DATA_BITS  = 16;
    localparam int ADDR_BITS  = 5;
    localparam int FRAME_BITS = PRE_BITS + HDR_BITS + TA_BITS + DATA_BITS;
    localparam int CNT_BITS   = $clog2(FRAME_BITS);
    localparam int DATA_FIRST = PRE_BITS + HDR_BITS + TA_BITS;

    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_IND  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [ADDR_BITS-1:0] phy;
        logic [ADDR_BITS-1:0] regad;
    } mgmt_addr_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: free-running MDC divider. It produces MDC plus single-cycle
// rise/fall tick strobes that are aligned with the clock edges on which
// MDC changes. Assumes CLK_DIV is even and at least 2.
module mdio_mdc_gen #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int HALF = CLK_DIV / 2;

    logic [CW-1:0] div_cnt;

    // Tick strobes decoded from the divider phase.
    always_comb begin
        rise_tick = (div_cnt == CW'(HALF - 1));
        fall_tick = (div_cnt == CW'(CLK_DIV - 1));
    end

    // Divider phase counter and MDC level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            mdc     <= 1'b0;
        end else begin
            div_cnt <= fall_tick ? '0 : div_cnt + 1'b1;
            if (rise_tick)      mdc <= 1'b1;
            else if (fall_tick) mdc <= 1'b0;
        end
    end

    // R2
    mdc_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_tick && fall_tick));
endmodule

// File: rtl/mdio_frame_seq.sv
// Module: read-frame sequencer. It steps through the 64 bit slots of a read
// frame on MDC falling ticks, drives preamble and header, and captures the
// 16 data bits on rising ticks. At the end of a frame it either restarts
// (continue_req) or goes idle. Assumes the tick strobes never coincide.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 start_req,
    input  logic                 continue_req,
    input  mgmt_addr_t           target,
    input  logic                 mdio_i,
    output logic                 active,
    output logic                 launch,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 done,
    output logic [DATA_BITS-1:0] word
);
    localparam logic [CNT_BITS-1:0] LAST_SLOT = CNT_BITS'(FRAME_BITS - 1);
    localparam logic [CNT_BITS-1:0] DATA_SLOT = CNT_BITS'(DATA_FIRST);

    logic [CNT_BITS-1:0]  slot;
    logic [HDR_BITS-1:0]  hdr_q;
    logic [DATA_BITS-1:0] shift_q;

    // {oe, value} for a given slot of the frame.
    function automatic logic [1:0] slot_drive(input logic [CNT_BITS-1:0] n,
                                              input logic [HDR_BITS-1:0] h);
        int idx;
        if (int'(n) < PRE_BITS) return 2'b11;
        if (int'(n) < PRE_BITS + HDR_BITS) begin
            idx = HDR_BITS - 1 - (int'(n) - PRE_BITS);
            return {1'b1, h[idx]};
        end
        return 2'b01;
    endfunction

    // Start strobe for a fresh (non-scan-continued) frame.
    always_comb launch = fall_tick && !active && start_req;

    // Slot stepping, output drive and frame restart/stop on falling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            slot    <= '0;
            hdr_q   <= '0;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
        end else if (fall_tick) begin
            if (!active || slot == LAST_SLOT) begin
                if (active ? continue_req : start_req) begin
                    active  <= 1'b1;
                    slot    <= '0;
                    hdr_q   <= {2'b01, 2'b10, target.phy, target.regad};
                    mdio_oe <= 1'b1;
                    mdio_o  <= 1'b1;
                end else begin
                    active  <= 1'b0;
                    slot    <= '0;
                    mdio_oe <= 1'b0;
                    mdio_o  <= 1'b1;
                end
            end else begin
                slot              <= slot + 1'b1;
                {mdio_oe, mdio_o} <= slot_drive(slot + 1'b1, hdr_q);
            end
        end
    end

    // Data capture on rising ticks and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            word    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (rise_tick && active && slot >= DATA_SLOT) begin
                shift_q <= {shift_q[DATA_BITS-2:0], mdio_i};
                if (slot == LAST_SLOT) begin
                    word <= {shift_q[DATA_BITS-2:0], mdio_i};
                    done <= 1'b1;
                end
            end
        end
    end

    // R3
    ta_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && slot >= CNT_BITS'(PRE_BITS + HDR_BITS)) |-> !mdio_oe);

    // R3
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mdio_oe);
endmodule

// File: rtl/mdio_scan_master.sv
// Module: top of the MDIO read master. It holds the address, command,
// indicator and status registers, detects the read-bit rising edge, and
// drives the divider and frame sequencer. Assumes single-cycle register
// writes and a combinational read mux.
module mdio_scan_master
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int AW = 2 * ADDR_BITS;

    mgmt_addr_t           target_q;
    logic                 cmd_read_q;
    logic                 cmd_scan_q;
    logic                 read_prev_q;
    logic                 pend_q;
    logic [DATA_BITS-1:0] status_q;
    logic                 rise_tick, fall_tick;
    logic                 seq_active, seq_launch, seq_done;
    logic [DATA_BITS-1:0] seq_word;
    logic                 busy;
    logic                 rd_rise;

    mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) i_mdc_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq i_frame_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise_tick    (rise_tick),
        .fall_tick    (fall_tick),
        .start_req    (pend_q | cmd_scan_q),
        .continue_req (cmd_scan_q),
        .target       (target_q),
        .mdio_i       (mdio_i),
        .active       (seq_active),
        .launch       (seq_launch),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe),
        .done         (seq_done),
        .word         (seq_word)
    );

    // Busy flag and read-bit edge detection.
    always_comb begin
        busy    = pend_q | seq_active | cmd_scan_q;
        rd_rise = cmd_read_q & ~read_prev_q;
    end

    // Software-written address and command registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q   <= '0;
            cmd_read_q <= 1'b0;
            cmd_scan_q <= 1'b0;
        end else if (reg_wr_en) begin
            if (reg_sel == SEL_ADDR) target_q <= mgmt_addr_t'(reg_wdata[AW-1:0]);
            if (reg_sel == SEL_CMD) begin
                cmd_read_q <= reg_wdata[0];
                cmd_scan_q <= reg_wdata[1];
            end
        end
    end

    // Pending single read: set by an accepted edge, cleared on launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            read_prev_q <= 1'b0;
            pend_q      <= 1'b0;
        end else begin
            read_prev_q <= cmd_read_q;
            if (seq_launch)         pend_q <= 1'b0;
            else if (rd_rise && !busy) pend_q <= 1'b1;
        end
    end

    // Status word loaded at the end of every frame.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else if (seq_done) status_q <= seq_word;
    end

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel_e'(reg_sel))
            SEL_ADDR: reg_rdata[AW-1:0] = target_q;
            SEL_CMD:  reg_rdata[1:0]    = {cmd_scan_q, cmd_read_q};
            SEL_IND:  reg_rdata[0]      = busy;
            SEL_STAT: reg_rdata         = status_q;
            default:  reg_rdata         = '0;
        endcase
    end

    // R2
    mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R6
    busy_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rise && !busy) |=> busy);

    // R7
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_done |=> $stable(status_q));

    // R8
    scan_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_scan_q |-> busy);

    // R10
    ignore_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rise && seq_active) |=> !pend_q);

    // R5
    no_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_read_q && !reg_wr_en) |=> cmd_read_q);
endmodule

// File: tb/test_mdio_scan_master.sv
// Bench: PHY model decodes frames from the MDIO pins and answers with
// {phy, reg, frame_index[5:0]}; a vector table walks single reads, then
// directed tests cover reset, MDC timing, ignored edges and scan.
module test_mdio_scan_master;
    localparam int CLK_DIV = 8;
    localparam int NVEC    = 6;
    localparam logic [9:0] VEC [NVEC] = '{
        {5'd1,  5'd0},  {5'd31, 5'd31}, {5'd5,  5'd1},
        {5'd16, 5'd10}, {5'd10, 5'd21}, {5'd2,  5'd30}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // PHY model state
    int          p_state = 0;
    int          ones = 0;
    int          hcnt = 0;
    int          dcnt = 0;
    int          ncnt = 0;
    int          frames = 0;
    int          fmt_err = 0;
    logic [11:0] hdr_sh = '0;
    logic [4:0]  cap_phy = '0;
    logic [4:0]  cap_reg = '0;
    logic [15:0] resp = '0;
    logic        phy_drive = 1'b0;
    logic        phy_bit = 1'b1;

    assign mdio_i = phy_drive ? phy_bit : 1'b1;

    always #2.5 clk = ~clk;

    mdio_scan_master #(.CLK_DIV(CLK_DIV)) i_mdio_scan_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    // PHY model: frame decode on MDC rising edges.
    always @(posedge mdc) begin
        case (p_state)
            0: begin
                if (mdio_oe && mdio_o) ones++;
                else if (mdio_oe && !mdio_o && ones >= 32) begin
                    if (ones != 32) fmt_err++;
                    p_state = 1; ones = 0;
                end else ones = 0;
            end
            1: begin
                if (mdio_oe && mdio_o) begin p_state = 2; hcnt = 0; end
                else begin fmt_err++; p_state = 0; end
            end
            2: begin
                if (!mdio_oe) fmt_err++;
                hdr_sh = {hdr_sh[10:0], mdio_o};
                hcnt++;
                if (hcnt == 12) begin
                    if (hdr_sh[11:10] != 2'b10) fmt_err++;
                    cap_phy = hdr_sh[9:5];
                    cap_reg = hdr_sh[4:0];
                    resp = {hdr_sh[9:5], hdr_sh[4:0], 6'(frames)};
                    p_state = 3; dcnt = 0; ncnt = 0;
                end
            end
            default: begin
                if (mdio_oe) fmt_err++;
                dcnt++;
                if (dcnt == 18) begin p_state = 0; frames++; end
            end
        endcase
    end

    // PHY model: response bits change on MDC falling edges.
    always @(negedge mdc) begin
        if (p_state == 3) begin
            ncnt++;
            if (ncnt >= 3 && ncnt <= 18) begin
                phy_drive = 1'b1;
                phy_bit   = resp[15 - (ncnt - 3)];
            end else phy_drive = 1'b0;
        end else phy_drive = 1'b0;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [15:0] v;
        int k;
        k = 0;
        rd(2'd2, v);
        while (v[0] && k < 5000) begin rd(2'd2, v); k++; end
        chk(req, {31'd0, v[0]}, 32'd0);
    endtask

    task automatic wait_frames(input int target);
        int k;
        k = 0;
        while (frames < target && k < 20000) begin @(negedge clk); k++; end
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL R6 watchdog actual=hung expected=complete");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int f0, t0, t1, t2, lows;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 addr", v, 0);
        rd(2'd1, v); chk("R1 cmd", v, 0);
        rd(2'd2, v); chk("R1 busy", v, 0);
        rd(2'd3, v); chk("R1 status", v, 0);
        chk("R1 mdio_oe", mdio_oe, 0);

        // R2 MDC period and duty
        @(posedge mdc); t0 = 0;
        while (mdc) begin @(posedge clk); #1 t0++; end
        t1 = t0;
        while (!mdc) begin @(posedge clk); #1 t1++; end
        chk("R2 mdc high clocks", t0, CLK_DIV / 2);
        chk("R2 mdc period clocks", t1, CLK_DIV);

        // Vector table: single reads at several addresses
        for (int i = 0; i < NVEC; i++) begin
            f0 = frames;
            wr(2'd0, {6'd0, VEC[i]});
            wr(2'd1, 16'h0001);
            repeat (2) @(negedge clk);
            rd(2'd2, v); chk("R6 busy after edge", v[0], 1);
            wait_idle("R6 busy clears");
            rd(2'd3, v); chk("R7 status data", v, {VEC[i], 6'(f0)});
            chk("R4 phy addr in frame", cap_phy, VEC[i][9:5]);
            chk("R4 reg addr in frame", cap_reg, VEC[i][4:0]);
            chk("R3 frame format errors", fmt_err, 0);
            rd(2'd1, v); chk("R5 read bit stays set", v, 16'h0001);
            repeat (2 * 64 * CLK_DIV) @(negedge clk);
            chk("R5 no repeat while held", frames, f0 + 1);
            wr(2'd1, 16'h0000);
        end

        // R10 edge during a frame ignored
        f0 = frames;
        wr(2'd0, {6'd0, 5'd7, 5'd3});
        wr(2'd1, 16'h0001);
        repeat (100) @(negedge clk);
        wr(2'd1, 16'h0000);
        wr(2'd1, 16'h0001);
        wait_idle("R10 busy clears");
        repeat (2 * 64 * CLK_DIV) @(negedge clk);
        chk("R10 single frame", frames, f0 + 1);
        rd(2'd2, v); chk("R10 idle after", v, 0);
        rd(2'd3, v); chk("R10 status", v, {5'd7, 5'd3, 6'(f0)});
        wr(2'd1, 16'h0000);

        // R8 scan mode: back-to-back frames, busy held
        f0 = frames;
        wr(2'd0, {6'd0, 5'd9, 5'd1});
        wr(2'd1, 16'h0002);
        lows = 0;
        t2 = 0;
        while (frames < f0 + 3 && t2 < 20000) begin
            rd(2'd2, v);
            if (!v[0]) lows++;
            t2++;
        end
        chk("R8 busy held in scan", lows, 0);
        chk("R8 back-to-back frames", (t2 < 3 * 64 * CLK_DIV + 80) ? 1 : 0, 1);
        repeat (4) @(negedge clk);
        rd(2'd3, v); chk("R8 status per frame", v, {5'd9, 5'd1, 6'(f0 + 2)});
        wait_frames(f0 + 4);
        repeat (4) @(negedge clk);
        rd(2'd3, v); chk("R8 status updated again", v, {5'd9, 5'd1, 6'(f0 + 3)});

        // R9 clear scan mid-frame: frame in progress finishes, then stop
        repeat (40) @(negedge clk);
        t0 = frames;
        wr(2'd1, 16'h0000);
        rd(2'd2, v); chk("R9 busy until frame end", v[0], 1);
        wait_idle("R9 busy clears");
        chk("R9 in-progress frame completes", frames, t0 + 1);
        rd(2'd3, v); chk("R9 last status", v, {5'd9, 5'd1, 6'(t0)});
        repeat (3 * 64 * CLK_DIV) @(negedge clk);
        chk("R9 no further frames", frames, t0 + 1);
        chk("R9 line released", mdio_oe, 0);
        chk("R3 format errors overall", fmt_err, 0);

        finished = 1;
        summary();
        $finish;
    end
endmodule